// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block connects a clocked host to an asynchronous dynamic memory whose address pins carry half of the word address at a time. For each single-word host request it drives the upper half of the address as the row and strobes it with an active-low row strobe. It then drives the lower half as the column and strobes it with an active-low column strobe. For a write it also drives the data with an active-low write enable. For a read it captures the returned word a fixed number of cycles after the column strobe falls.

Because the storage cells leak, a free-running interval timer requests a row-only refresh. The timer period is the retention time divided by the row count. During a refresh the row strobe falls on a refresh row pointer, and the column strobe stays high. A pending refresh wins over a waiting host request, but never cuts short an access that has already started. Every strobe cycle is followed by a precharge gap before the row strobe may fall again.

All strobe, enable and address pins come straight from flops, so no decode glitch reaches the memory. The host side uses a valid/ready handshake for requests and a one-cycle valid pulse for read data.

Top module: `dram_ctrl`

## Requirements
- R1: For an accepted request, the row strobe falls with req_addr[2*ROW_W-1:ROW_W] on dram_addr, and the column strobe falls with req_addr[ROW_W-1:0] on dram_addr.
- R2: dram_addr holds the same value for at least one full cycle before the row strobe falls, and for at least one full cycle before the column strobe falls.
- R3: In a host access the column strobe falls exactly T_RCD+1 cycles after the row strobe falls, and stays low for exactly T_CAS cycles. The column strobe is never low while the row strobe is high.
- R4: For a write, dram_we_n is low and dram_dq_oe is high from one cycle before the column strobe falls, with dram_dq_out equal to the request data. dram_we_n does not change while the column strobe is low. For a read, dram_we_n stays high and dram_dq_oe stays low.
- R5: For a read, dram_dq_in is sampled in the last cycle of the column strobe. rsp_valid pulses for one cycle in the cycle the column strobe returns high, carrying that word. Responses come in request order.
- R6: A refresh drives the refresh row pointer on dram_addr and holds the row strobe low for exactly T_RAS cycles, with the column strobe high. The pointer starts at 0 and advances by one, wrapping modulo 2^ROW_W, after each refresh.
- R7: A refresh becomes pending every RETENTION_CYC / 2^ROW_W cycles. The k-th refresh row strobe falls no earlier than 2 cycles after the k-th period expires, and no later than 12 cycles after it (default timings of the bench).
- R8: While a refresh is pending no host request is accepted. An access that has already begun runs to its end.
- R9: Between a rise and the next fall of the row strobe there are at least T_RP+1 cycles with both strobes high.
- R10: req_ready is high only when both strobes are high, the block is idle and no refresh is pending. A request is accepted on a cycle with req_valid and req_ready both high.
- R11: After reset both strobes and dram_we_n are high, dram_dq_oe and rsp_valid are low, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*ROW_W | Word address, row in upper half |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DATA_W | Read data |
| dram_addr | output | ROW_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Active-low row strobe |
| dram_cas_n | output | 1 | Active-low column strobe |
| dram_we_n | output | 1 | Active-low write enable |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_out | output | DATA_W | Data driven to the memory |
| dram_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The hardest case to reach from the ports is a refresh period that expires while a host request is already waiting, or while an access is in progress. Only then do the priority and no-interrupt rules matter. The stimulus keeps req_valid raised again right after every handshake, across several dozen refresh periods, so the timer expiry lands at many different phases of an access. Long runs also carry the refresh row pointer through several wraps. Read-back of untouched addresses returns a pattern keyed on the row and column the memory model latched, so any swap of address halves shows up as a data mismatch.

// File: rtl/dram_ctrl_pkg.sv
`timescale 1ns/1ps
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ROW_SU   = 3'd1,
        ST_ROW_HOLD = 3'd2,
        ST_COL_SU   = 3'd3,
        ST_CAS      = 3'd4,
        ST_REF_SU   = 3'd5,
        ST_REF_RAS  = 3'd6,
        ST_PRE      = 3'd7
    } seq_state_e;

    typedef enum logic [1:0] {
        ASEL_HOLD = 2'd0,
        ASEL_ROW  = 2'd1,
        ASEL_COL  = 2'd2,
        ASEL_REF  = 2'd3
    } addr_sel_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STROBE_REST = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    // Pin levels that belong to a sequencer state
    function automatic strobe_t strobe_decode(seq_state_e s, logic is_write);
        strobe_t st;
        st = STROBE_REST;
        case (s)
            ST_ROW_HOLD: st.ras_n = 1'b0;
            ST_COL_SU: begin
                st.ras_n = 1'b0;
                st.we_n  = ~is_write;
                st.dq_oe = is_write;
            end
            ST_CAS: begin
                st.ras_n = 1'b0;
                st.cas_n = 1'b0;
                st.we_n  = ~is_write;
                st.dq_oe = is_write;
            end
            ST_REF_RAS: st.ras_n = 1'b0;
            default: st = STROBE_REST;
        endcase
        return st;
    endfunction

    function automatic addr_sel_e addr_select(seq_state_e s);
        case (s)
            ST_ROW_SU, ST_ROW_HOLD: return ASEL_ROW;
            ST_COL_SU, ST_CAS:      return ASEL_COL;
            ST_REF_SU, ST_REF_RAS:  return ASEL_REF;
            default:                return ASEL_HOLD;
        endcase
    endfunction

    function automatic int unsigned wait_cnt_width(int unsigned a, int unsigned b,
                                                   int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return (m > 1) ? $clog2(m) : 1;
    endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
`timescale 1ns/1ps
module dram_refresh_timer #(
    parameter int unsigned INTERVAL = 12500,
    parameter int unsigned ROW_W    = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_take,
    input  logic             ref_done,
    output logic             ref_pending,
    output logic [ROW_W-1:0] ref_row
);
    localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [TW-1:0] tick_cnt;
    logic          tick;

    assign tick = (tick_cnt == TW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt    <= '0;
            ref_pending <= 1'b0;
            ref_row     <= '0;
        end else begin
            tick_cnt    <= tick ? '0 : tick_cnt + 1'b1;
            ref_pending <= (ref_pending & ~ref_take) | tick;
            if (ref_done)
                ref_row <= ref_row + 1'b1;
        end
    end

    // R7
    pending_held_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_pending && !ref_take) |=> ref_pending);

    // R6
    row_advance_chk: assert property (@(posedge clk) disable iff (rst)
        ref_done |=> (ref_row == ROW_W'($past(ref_row) + 1'b1)));

endmodule

// File: rtl/dram_seq_fsm.sv
`timescale 1ns/1ps
module dram_seq_fsm
    import dram_ctrl_pkg::*;
#(
    parameter int unsigned T_RCD = 2,
    parameter int unsigned T_CAS = 2,
    parameter int unsigned T_RP  = 3,
    parameter int unsigned T_RAS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       cur_write,
    input  logic       ref_pending,
    output seq_state_e state_q,
    output seq_state_e state_d,
    output logic       req_ready,
    output logic       ref_take,
    output logic       ref_done,
    output logic       rd_sample
);
    localparam int unsigned CW = wait_cnt_width(T_RCD, T_CAS, T_RP, T_RAS);

    logic [CW-1:0] cnt_q, cnt_d;

    assign req_ready = (state_q == ST_IDLE) && !ref_pending;

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        ref_take  = 1'b0;
        ref_done  = 1'b0;
        rd_sample = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (ref_pending) begin
                    state_d  = ST_REF_SU;
                    ref_take = 1'b1;
                end else if (req_valid) begin
                    state_d = ST_ROW_SU;
                end
            end
            ST_ROW_SU: begin
                state_d = ST_ROW_HOLD;
                cnt_d   = CW'(T_RCD - 1);
            end
            ST_ROW_HOLD: begin
                if (cnt_q == '0) state_d = ST_COL_SU;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_COL_SU: begin
                state_d = ST_CAS;
                cnt_d   = CW'(T_CAS - 1);
            end
            ST_CAS: begin
                if (cnt_q == '0) begin
                    state_d   = ST_PRE;
                    cnt_d     = CW'(T_RP - 1);
                    rd_sample = !cur_write;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_REF_SU: begin
                state_d = ST_REF_RAS;
                cnt_d   = CW'(T_RAS - 1);
            end
            ST_REF_RAS: begin
                if (cnt_q == '0) begin
                    state_d  = ST_PRE;
                    cnt_d    = CW'(T_RP - 1);
                    ref_done = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_PRE: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // R8
    refresh_first_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && ref_pending) |=> (state_q == ST_REF_SU));

    // R8
    access_not_cut_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CAS) |=> (state_q == ST_CAS || state_q == ST_PRE));

endmodule

// File: rtl/dram_addr_mux.sv
`timescale 1ns/1ps
module dram_addr_mux
    import dram_ctrl_pkg::*;
#(
    parameter int unsigned ROW_W = 10
) (
    input  addr_sel_e        sel,
    input  logic [ROW_W-1:0] hold_addr,
    input  logic [ROW_W-1:0] row_addr,
    input  logic [ROW_W-1:0] col_addr,
    input  logic [ROW_W-1:0] ref_addr,
    output logic [ROW_W-1:0] next_addr
);
    always_comb begin
        case (sel)
            ASEL_ROW: next_addr = row_addr;
            ASEL_COL: next_addr = col_addr;
            ASEL_REF: next_addr = ref_addr;
            default:  next_addr = hold_addr;
        endcase
    end
endmodule

// File: rtl/dram_ctrl.sv
`timescale 1ns/1ps
module dram_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int unsigned ROW_W         = 10,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned RETENTION_CYC = 12800000,
    parameter int unsigned T_RCD         = 2,
    parameter int unsigned T_CAS         = 2,
    parameter int unsigned T_RP          = 3,
    parameter int unsigned T_RAS         = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [2*ROW_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [ROW_W-1:0]     dram_addr,
    output logic                 dram_ras_n,
    output logic                 dram_cas_n,
    output logic                 dram_we_n,
    output logic                 dram_dq_oe,
    output logic [DATA_W-1:0]    dram_dq_out,
    input  logic [DATA_W-1:0]    dram_dq_in
);
    localparam int unsigned ADDR_W       = 2 * ROW_W;
    localparam int unsigned ROWS         = 1 << ROW_W;
    localparam int unsigned REF_INTERVAL = RETENTION_CYC / ROWS;
    localparam int unsigned HW           = $clog2(T_RP + 2) + 1;

    typedef struct packed {
        logic              write;
        logic [ROW_W-1:0]  row;
        logic [ROW_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
    } host_req_t;

    host_req_t        req_q;
    seq_state_e       state_q, state_d;
    strobe_t          pins_q;
    logic [ROW_W-1:0] addr_q, addr_d, ref_row, row_src;
    logic             ref_pending, ref_take, ref_done, rd_sample, req_fire;

    assign req_fire = req_valid && req_ready;
    assign row_src  = req_fire ? req_addr[ADDR_W-1:ROW_W] : req_q.row;

    dram_refresh_timer #(.INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)) u_timer (
        .clk(clk), .rst(rst), .ref_take(ref_take), .ref_done(ref_done),
        .ref_pending(ref_pending), .ref_row(ref_row)
    );

    dram_seq_fsm #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS(T_RAS)) u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .cur_write(req_q.write),
        .ref_pending(ref_pending), .state_q(state_q), .state_d(state_d),
        .req_ready(req_ready), .ref_take(ref_take), .ref_done(ref_done),
        .rd_sample(rd_sample)
    );

    dram_addr_mux #(.ROW_W(ROW_W)) u_amux (
        .sel(addr_select(state_d)), .hold_addr(addr_q), .row_addr(row_src),
        .col_addr(req_q.col), .ref_addr(ref_row), .next_addr(addr_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (req_fire) begin
            req_q.write <= req_write;
            req_q.row   <= req_addr[ADDR_W-1:ROW_W];
            req_q.col   <= req_addr[ROW_W-1:0];
            req_q.wdata <= req_wdata;
        end
    end

    // Pins are registered from the next state so they never glitch
    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q    <= STROBE_REST;
            addr_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            pins_q    <= strobe_decode(state_d, req_q.write);
            addr_q    <= addr_d;
            rsp_valid <= rd_sample;
            if (rd_sample)
                rsp_rdata <= dram_dq_in;
        end
    end

    assign dram_addr   = addr_q;
    assign dram_ras_n  = pins_q.ras_n;
    assign dram_cas_n  = pins_q.cas_n;
    assign dram_we_n   = pins_q.we_n;
    assign dram_dq_oe  = pins_q.dq_oe;
    assign dram_dq_out = req_q.wdata;

    // Checker state: cycles the row strobe has been high
    logic [HW-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst)
            hi_run <= HW'(T_RP + 1);
        else if (!dram_ras_n)
            hi_run <= '0;
        else if (hi_run != '1)
            hi_run <= hi_run + 1'b1;
    end

    // R3
    cas_inside_ras_chk: assert property (@(posedge clk) disable iff (rst)
        !dram_cas_n |-> !dram_ras_n);

    // R2
    row_addr_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> $stable(dram_addr));

    // R4
    we_setup_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_cas_n) && !dram_we_n) |-> ($past(dram_we_n) == 1'b0));

    // R9
    precharge_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> (hi_run >= HW'(T_RP + 1)));

    // R10
    ready_when_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (dram_ras_n && dram_cas_n));

    // R5
    rsp_at_cas_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $rose(dram_cas_n));

endmodule

// File: tb/tb_dram_ctrl.sv
`timescale 1ns/1ps
module tb_dram_ctrl;
    localparam int RW   = 4;
    localparam int DW   = 16;
    localparam int RET  = 640;
    localparam int TRCD = 2;
    localparam int TCAS = 2;
    localparam int TRP  = 2;
    localparam int TRAS = 3;
    localparam int COLS = 1 << RW;
    localparam int INTV = RET / COLS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [2*RW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata, dram_dq_out, dram_dq_in;
    logic [RW-1:0] dram_addr;
    logic          dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;

    always #2.5 clk = ~clk;

    dram_ctrl #(.ROW_W(RW), .DATA_W(DW), .RETENTION_CYC(RET), .T_RCD(TRCD),
                .T_CAS(TCAS), .T_RP(TRP), .T_RAS(TRAS)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_dq_oe(dram_dq_oe), .dram_dq_out(dram_dq_out), .dram_dq_in(dram_dq_in)
    );

    int tests = 0, fails = 0, cyc = 0, wd = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int k);
        return DW'((k * 37) ^ 16'hA5C3);
    endfunction

    // Memory model and host-side reference
    logic [DW-1:0] mem [int];
    logic [DW-1:0] shadow [int];
    logic [DW-1:0] rd_exp [$];
    logic [DW-1:0] dq_model = '0;
    assign dram_dq_in = dq_model;

    logic          prev_ras, prev_cas, prev_we;
    logic [RW-1:0] prev_addr, m_row, exp_ref_row = '0;
    int            hi_cnt, low_cnt, cas_cnt, ref_seen = 0;
    bit            host_out = 0, cur_ref = 0, cur_wr = 0, h_wr = 0;
    logic [RW-1:0] h_row, h_col, cur_row, cur_col;
    logic [DW-1:0] h_data, cur_data;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (rst) begin
            prev_ras = 1; prev_cas = 1; prev_we = 1; prev_addr = dram_addr;
            hi_cnt = 100; low_cnt = 0; cas_cnt = 0;
        end else begin
            if (req_ready) check(dram_ras_n && dram_cas_n, "R10", {dram_ras_n, dram_cas_n}, 3);
            if (!dram_cas_n) check(!dram_ras_n, "R3", dram_ras_n, 0);

            if (prev_ras && !dram_ras_n) begin
                check(hi_cnt >= TRP + 1, "R9", hi_cnt, TRP + 1);
                check(dram_addr == prev_addr, "R2", dram_addr, prev_addr);
                if (host_out) begin
                    cur_ref = 0; cur_row = h_row; cur_col = h_col;
                    cur_wr = h_wr; cur_data = h_data; host_out = 0;
                    check(dram_addr == cur_row, "R1", dram_addr, cur_row);
                end else begin
                    cur_ref = 1;
                    check(dram_addr == exp_ref_row, "R6", dram_addr, exp_ref_row);
                    check(cyc >= (ref_seen + 1) * INTV + 2 && cyc <= (ref_seen + 1) * INTV + 12,
                          "R7", cyc, (ref_seen + 1) * INTV + 2);
                    ref_seen++;
                    exp_ref_row = exp_ref_row + 1'b1;
                end
                m_row = dram_addr;
                low_cnt = 1;
            end else if (!dram_ras_n) begin
                low_cnt++;
            end

            if (prev_cas && !dram_cas_n) begin
                int key;
                check(!cur_ref, "R6", cur_ref, 0);
                check(low_cnt == TRCD + 2, "R3", low_cnt, TRCD + 2);
                check(dram_addr == cur_col, "R1", dram_addr, cur_col);
                check(dram_addr == prev_addr, "R2", dram_addr, prev_addr);
                key = int'(m_row) * COLS + int'(dram_addr);
                if (cur_wr) begin
                    check(!prev_we && !dram_we_n && dram_dq_oe, "R4", {prev_we, dram_we_n, dram_dq_oe}, 1);
                    check(dram_dq_out == cur_data, "R4", dram_dq_out, cur_data);
                    mem[key] = dram_dq_out;
                end else begin
                    check(dram_we_n && !dram_dq_oe, "R4", {dram_we_n, dram_dq_oe}, 2);
                    dq_model = mem.exists(key) ? mem[key] : pat(key);
                end
                cas_cnt = 1;
            end else if (!dram_cas_n) begin
                cas_cnt++;
                check(dram_we_n == prev_we, "R4", dram_we_n, prev_we);
            end
            if (!prev_cas && dram_cas_n) check(cas_cnt == TCAS, "R3", cas_cnt, TCAS);

            if (!prev_ras && dram_ras_n) begin
                if (cur_ref) check(low_cnt == TRAS, "R6", low_cnt, TRAS);
                hi_cnt = 1;
            end else if (dram_ras_n) begin
                hi_cnt++;
            end

            if (rsp_valid) begin
                check(!prev_cas && dram_cas_n, "R5", {prev_cas, dram_cas_n}, 1);
                if (rd_exp.size() == 0) check(0, "R5", rsp_rdata, 0);
                else begin
                    logic [DW-1:0] e;
                    e = rd_exp.pop_front();
                    check(rsp_rdata == e, "R5", rsp_rdata, e);
                end
            end

            if (req_valid && req_ready) begin
                int a;
                a = int'(req_addr);
                // R8: no acceptance once a refresh period has expired
                check((ref_seen + 1) * INTV > cyc, "R8", cyc, (ref_seen + 1) * INTV);
                h_row = req_addr[2*RW-1:RW]; h_col = req_addr[RW-1:0];
                h_wr = req_write; h_data = req_wdata; host_out = 1;
                if (req_write) shadow[a] = req_wdata;
                else rd_exp.push_back(shadow.exists(a) ? shadow[a] : pat(a));
            end

            prev_ras = dram_ras_n; prev_cas = dram_cas_n;
            prev_we = dram_we_n; prev_addr = dram_addr;
        end
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 100000);
            finish_run();
        end
    end

    task automatic host_op(input bit wr, input logic [2*RW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (5) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R11 reset state
        check(dram_ras_n == 1, "R11", dram_ras_n, 1);
        check(dram_cas_n == 1, "R11", dram_cas_n, 1);
        check(dram_we_n == 1, "R11", dram_we_n, 1);
        check(dram_dq_oe == 0, "R11", dram_dq_oe, 0);
        check(rsp_valid == 0, "R11", rsp_valid, 0);
        check(req_ready == 1, "R11", req_ready, 1);

        // R1 corner addresses, R4 writes, R5 reads
        host_op(1, 8'h00, 16'h1111);
        host_op(1, 8'hFF, 16'h2222);
        host_op(1, 8'hF0, 16'h3333);
        host_op(1, 8'h0F, 16'h4444);
        host_op(0, 8'h00, '0);
        host_op(0, 8'hFF, '0);
        host_op(0, 8'hF0, '0);
        host_op(0, 8'h0F, '0);
        host_op(0, 8'h5A, '0);   // never written
        host_op(1, 8'h0F, 16'hBEEF);
        host_op(0, 8'h0F, '0);

        // R8 stream that keeps colliding with refresh expiry
        lfsr = 16'hACE1;
        for (int i = 0; i < 240; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            host_op(lfsr[0], 8'(lfsr[5:1] * 7), lfsr ^ 16'h5555);
        end

        // R6 R7 refresh only
        repeat (400) @(posedge clk);
        @(negedge clk);
        check(rd_exp.size() == 0, "R5", rd_exp.size(), 0);
        check(ref_seen >= cyc / INTV - 1 && ref_seen <= cyc / INTV, "R7", ref_seen, cyc / INTV);
        check(ref_seen > 2 * COLS, "R6", ref_seen, 2 * COLS);
        done = 1;
        finish_run();
    end
endmodule